// File: doc/BRIEF.md
# Programmable Edge/Change Interrupt Source

This block turns one asynchronous input pin into an interrupt. The pin is brought into the clock domain by a two-flop synchronizer. Its synchronized level can be read back. A detector compares the synchronized value with the value it had one clock earlier, and raises a one-cycle trigger on a condition chosen by two control bits. The condition is a rising edge, a falling edge, or any change of level.

The trigger sets a sticky pending flag, which software clears by writing 1 to it. When the enable bit is also set, the pending flag drives a registered interrupt output. Software reaches six one-bit registers through a simple write strobe with a combinational read port. The registers are the input level, the detection mode, the edge polarity, the raw trigger, the pending flag and the enable. Unmapped addresses and unused read bits return zero.

Top module: `gpio_event_irq`

## Requirements
- R1: Reading address 0 returns the pin level in bit 0, two rising clock edges after the pin settles.
- R2: With mode (address 1) at 0 and polarity (address 2) at 0, a rising edge of the synchronized pin sets pending (address 4, bit 0), and a falling edge does not.
- R3: With mode 0 and polarity 1, a falling edge sets pending, and a rising edge does not.
- R4: With mode 1, every change of the synchronized level sets pending, whatever the polarity.
- R5: Address 3, bit 0 reads the raw trigger. The trigger is high only in the single cycle in which a qualifying transition is being detected. Writes to address 3 change nothing.
- R6: Pending is sticky. Writing 1 to address 4 clears it, and writing 0 leaves it unchanged. A trigger in the same cycle as a clearing write leaves it set.
- R7: The irq output is 1 in the cycle after pending and enable (address 5, bit 0) are both 1. While enable is 0, irq stays 0.
- R8: After the synchronous active-low reset, all readable registers are 0 and irq is 0.
- R9: Writing mode or polarity while the pin is stable does not set pending.
- R10: Addresses 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 1 | Asynchronous input pin being watched |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Register address (0 level, 1 mode, 2 polarity, 3 trigger, 4 pending, 5 enable) |
| reg_wbit | input | 1 | Write data bit |
| reg_rdata | output | DATA_W | Read data for reg_addr, with bit 0 meaningful and the rest zero |
| irq | output | 1 | Registered interrupt request |

## Verification
The pin is toggled in both directions under each of the three detection settings. This separates the rising-only, falling-only and any-change behaviour, and shows a mix-up of polarity or mode. Mode and polarity are rewritten while the pin is held stable, which shows whether a setting change alone creates an event. One clearing write is timed into the very cycle of a trigger to confirm that set wins over clear. The enable is toggled around a pending event to show the one-cycle registered delay of irq and its masking.

// File: rtl/gpio_event_irq_pkg.sv
// Shared definitions for the edge/change interrupt source.
// Assumes a register address of at least 3 bits.
package gpio_event_irq_pkg;
    localparam int unsigned REG_LEVEL  = 0;
    localparam int unsigned REG_MODE   = 1;
    localparam int unsigned REG_POL    = 2;
    localparam int unsigned REG_TRIG   = 3;
    localparam int unsigned REG_PEND   = 4;
    localparam int unsigned REG_ENAB   = 5;
    localparam int unsigned REG_COUNT  = 6;

    typedef enum logic {
        DET_EDGE   = 1'b0,
        DET_CHANGE = 1'b1
    } det_mode_e;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/pin_sync.sv
// Multi-flop synchronizer for one asynchronous bit.
// Assumes STAGES >= 2. The output lags the pin by STAGES clock edges.
// Every flop resets to 0.
module pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
        end
    end

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/trig_detect.sv
// Transition detector. It holds the previous synchronized sample and raises
// trig for one cycle when the selected condition is seen.
// Assumes level is already synchronous to clk.
module trig_detect
    import gpio_event_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  det_mode_e mode,
    input  edge_pol_e pol,
    output logic      trig
);
    logic prev_q;
    logic rise;
    logic fall;

    // Keep the sample from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    // Select the qualifying transition.
    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        if (mode == DET_CHANGE) begin
            trig = rise | fall;
        end else if (pol == POL_FALL) begin
            trig = fall;
        end else begin
            trig = rise;
        end
    end

    // R3
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_EDGE && pol == POL_FALL && $rose(level)) |-> !trig);

    // R2
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_EDGE && pol == POL_RISE && $fell(level)) |-> !trig);

    // R4
    any_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_CHANGE && !$stable(level)) |-> trig);
endmodule

// File: rtl/event_latch.sv
// Sticky pending flag with write-1-to-clear and a registered, masked
// interrupt. When set and clear come in the same cycle, set wins.
module event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clr,
    input  logic enable,
    output logic pending,
    output logic irq
);
    // Update the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else begin
            pending <= (pending & ~clr) | trig;
        end
    end

    // Register the masked request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= pending & enable;
        end
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pending);

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !trig) |=> !pending);

    // R7
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq);
endmodule

// File: rtl/gpio_event_irq.sv
// Top level of the single-pin edge/change interrupt source. It holds the
// control registers, decodes writes and drives the combinational read mux.
// Assumes ADDR_W >= 3 and DATA_W >= 1. Reads have no side effects.
module gpio_event_irq
    import gpio_event_irq_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_async,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wbit,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(REG_LEVEL);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(REG_MODE);
    localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(REG_POL);
    localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(REG_TRIG);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(REG_PEND);
    localparam logic [ADDR_W-1:0] A_ENAB  = ADDR_W'(REG_ENAB);

    logic      level;
    logic      trig;
    logic      pending;
    logic      enable_q;
    det_mode_e mode_q;
    edge_pol_e pol_q;
    logic      clr;
    logic      bit0;

    pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_async),
        .level (level)
    );

    trig_detect det_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level),
        .mode  (mode_q),
        .pol   (pol_q),
        .trig  (trig)
    );

    assign clr = reg_wr && (reg_addr == A_PEND) && reg_wbit;

    event_latch evt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .clr     (clr),
        .enable  (enable_q),
        .pending (pending),
        .irq     (irq)
    );

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= DET_EDGE;
            pol_q    <= POL_RISE;
            enable_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_MODE) mode_q   <= det_mode_e'(reg_wbit);
            if (reg_addr == A_POL)  pol_q    <= edge_pol_e'(reg_wbit);
            if (reg_addr == A_ENAB) enable_q <= reg_wbit;
        end
    end

    // Read mux for the addressed register.
    always_comb begin
        unique case (reg_addr)
            A_LEVEL: bit0 = level;
            A_MODE:  bit0 = mode_q;
            A_POL:   bit0 = pol_q;
            A_TRIG:  bit0 = trig;
            A_PEND:  bit0 = pending;
            A_ENAB:  bit0 = enable_q;
            default: bit0 = 1'b0;
        endcase
        reg_rdata = {{(DATA_W-1){1'b0}}, bit0};
    end

    // R9
    setting_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(level) && $past(!pending) && $past(!trig) && !trig) |-> !pending);
endmodule

// File: tb/gpio_event_irq_tb.sv
// Bench: a behavioural reference model checked against the design on every clock.
module gpio_event_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin_async = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wbit = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_event_irq #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wbit(reg_wbit), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Reference model state
    bit hist[$] = '{1'b0, 1'b0, 1'b0};  // pin samples, newest last
    bit m_mode = 0, m_pol = 0, m_en = 0, m_pend = 0, m_irq = 0;

    function automatic bit model_trig(bit cur, bit old, bit md, bit pl);
        if (md) return cur != old;
        if (pl) return old && !cur;
        return cur && !old;
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return int'(hist[1]);
            1: return int'(m_mode);
            2: return int'(m_pol);
            3: return int'(model_trig(hist[1], hist[0], m_mode, m_pol));
            4: return int'(m_pend);
            5: return int'(m_en);
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int a);
        case (a)
            0: return "R1";
            3: return "R5";
            4: return "R6";
            6, 7: return "R10";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{1'b0, 1'b0, 1'b0};
            m_mode = 0; m_pol = 0; m_en = 0; m_pend = 0; m_irq = 0;
        end else begin
            bit t;
            bit c;
            t = model_trig(hist[1], hist[0], m_mode, m_pol);
            c = reg_wr && reg_addr == 3'd4 && reg_wbit;
            m_irq = m_pend && m_en;
            m_pend = (m_pend && !c) || t;
            if (reg_wr && reg_addr == 3'd1) m_mode = reg_wbit;
            if (reg_wr && reg_addr == 3'd2) m_pol = reg_wbit;
            if (reg_wr && reg_addr == 3'd5) m_en = reg_wbit;
            hist.push_back(pin_async);
            void'(hist.pop_front());
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (irq !== m_irq) begin
                bad++;
                $display("FAIL R7 irq actual=%0b expected=%0b t=%0t", irq, m_irq, $time);
            end
            total++;
            if (reg_rdata !== DW'(model_read(int'(reg_addr)))) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%0h expected=%0h t=%0t",
                         req_of(int'(reg_addr)), reg_addr, reg_rdata,
                         model_read(int'(reg_addr)), $time);
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, bit d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wbit = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic set_pin(bit v);
        @(negedge clk); #1;
        pin_async = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_check(int a, int exp, string req);
        @(negedge clk); #1;
        reg_addr = AW'(a);
        @(negedge clk);
        check(reg_rdata == DW'(exp), req, int'(reg_rdata), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk); #1 rst_n = 1'b1;
        // R8 reset state
        check(irq == 1'b0, "R8 irq", int'(irq), 0);
        for (int a = 0; a < 6; a++) rd_check(a, 0, "R8");
        // R1 level and R2 rising edge, R7 masked
        set_pin(1); idle(4);
        rd_check(0, 1, "R1 level");
        rd_check(4, 1, "R2 rise sets");
        check(irq == 1'b0, "R7 masked", int'(irq), 0);
        // R6 write 0 keeps, write 1 clears
        wr(4, 0); rd_check(4, 1, "R6 write0 keeps");
        wr(4, 1); rd_check(4, 0, "R6 write1 clears");
        // R2 falling ignored
        set_pin(0); idle(4);
        rd_check(4, 0, "R2 fall ignored");
        rd_check(0, 0, "R1 level low");
        // R7 enabled interrupt
        wr(5, 1);
        reg_addr = 3'd3;
        set_pin(1); idle(5);
        check(irq == 1'b1, "R7 irq on", int'(irq), 1);
        wr(4, 1); idle(2);
        check(irq == 1'b0, "R7 irq off", int'(irq), 0);
        // R3 falling polarity
        wr(2, 1);
        set_pin(0); idle(4);
        rd_check(4, 1, "R3 fall sets");
        wr(4, 1);
        set_pin(1); idle(4);
        rd_check(4, 0, "R3 rise ignored");
        // R4 any change
        wr(1, 1);
        set_pin(0); idle(4);
        rd_check(4, 1, "R4 fall sets");
        wr(4, 1);
        wr(2, 0);
        set_pin(1); idle(4);
        rd_check(4, 1, "R4 rise sets");
        wr(4, 1);
        // R9 settings change with stable pin
        wr(1, 0); wr(2, 1); wr(1, 1); wr(2, 0); idle(3);
        rd_check(4, 0, "R9 no event");
        // R5 status ignores writes
        wr(3, 1); rd_check(3, 0, "R5 write ignored");
        // R6 set wins over clear in the same cycle
        wr(4, 1);
        reg_addr = 3'd3;
        set_pin(0);
        @(negedge clk);
        wr(4, 1);
        idle(1);
        rd_check(4, 1, "R6 set wins");
        // R10 unmapped addresses
        wr(6, 1); wr(7, 1);
        rd_check(6, 0, "R10 addr6");
        rd_check(7, 0, "R10 addr7");
        rd_check(5, 1, "R10 enable intact");
        rd_check(1, 1, "R10 mode intact");
        idle(4);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule